// File: doc/BRIEF.md
# Daisy-Chainable Serial Result Output Port

This block is the output side of a converter's serial port. It receives each finished conversion word and its status flags on a parallel input with a one-cycle strobe. It sends them as 32-bit frames on a serial data line. The serial clock it drives runs at half the master clock. An active-low frame marker stays low for the 32 bits that belong to this converter. Each frame packs the 24-bit result, five status flags and three zero bits. A register-read request swaps a 16-bit register value into the next frame, once.

Several converters can share one data line. They are wired in a chain, each serial output feeding the serial input of the device upstream. After its own 32 bits, the port keeps clocking out the bits that arrive on its serial input, so the words of the downstream devices follow its own. A depth input sets the number of downstream words. The port caps that number at the decimation rate divided by 32, minus one.

A three-state controller drives the port:
- `ST_IDLE` holds the frame marker high and the data line low.
- `ST_LOCAL` shifts out the local word.
- `ST_FORWARD` shifts out the downstream bits.

Its transitions are:
- *start*: `ST_IDLE`→`ST_LOCAL`, at a launch edge while a word is pending.
- *hand-over*: `ST_LOCAL`→`ST_FORWARD`, after bit 31 when the latched depth is non-zero.
- *local end*: `ST_LOCAL`→`ST_IDLE`, after bit 31 when the depth is zero.
- *chain end*: `ST_FORWARD`→`ST_IDLE`, after the last forwarded bit.

Every frame ends with at least one idle serial cycle.

Top module: `serial_result_port`

## Requirements
- R1: `sco` toggles on every master clock edge once reset is released. Its first rise is at the first edge after release, so its period is two master clocks.
- R2: `fso_n` falls together with the MSB of a frame and stays low for exactly 32 serial clock cycles.
- R3: Bits go out MSB first. `sdo` and `fso_n` change only at master clock edges where `sco` rises.
- R4: A conversion frame holds the following fields:
  - bits 31:8: the data word.
  - bit 7: `stat_settled`.
  - bit 6: `stat_ovr`.
  - bit 5: `stat_lowpwr`.
  - bits 4:3: `stat_dec`.
  - bits 2:0: zero.
- R5: After an `rd_stb`, the next frame is `{rd_word, 16'h0000}`. It uses up the pending conversion word. The frames after it carry conversion results again.
- R6: After the local 32 bits, the port sends 32×N more bits with `fso_n` high, where N is the latched depth. Forwarded bit j is the `sdi` value sampled at the j-th falling `sco` edge of the frame, counting the first falling edge as 0.
- R7: N is the smaller of `chain_depth` and a limit set by the `stat_dec` code of the word being sent. Code 2'b00 means rate 128 and a limit of 3 words. Any other code means rate 256 and a limit of 7 words.
- R8: With `sdi` held low, forwarded bits are zero. Between frames `fso_n` is high and `sdo` is low.
- R9: A word strobed while a frame is being shifted leaves that frame unchanged. The new word is sent in the next frame, which starts one serial cycle after the last bit.
- R10: During reset `sco` is low, `fso_n` is high and `sdo` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | One-cycle strobe: new conversion word and status |
| word_data | input | 24 | Conversion result |
| stat_settled | input | 1 | Filter-settled flag |
| stat_ovr | input | 1 | Overrange flag |
| stat_lowpwr | input | 1 | Low-power flag |
| stat_dec | input | 2 | Decimation-rate code (00 = 128, others = 256) |
| rd_stb | input | 1 | One-cycle strobe: send `rd_word` in the next frame |
| rd_word | input | 16 | Register contents for readback |
| chain_depth | input | 3 | Number of downstream devices in the chain |
| sdi | input | 1 | Serial input from the downstream device |
| sco | output | 1 | Serial clock, master clock divided by 2 |
| fso_n | output | 1 | Active-low frame marker |
| sdo | output | 1 | Serial data output |

## Verification
The hardest case to reach is a frame running while the pending buffer changes underneath it. The stimulus forks a strobe into the middle of a frame that is being received. It then checks two things: the running frame is untouched, and the new word starts exactly one serial cycle after it. The depth clamp is also hard to reach, because it depends on the status code of the word itself. The bench therefore sweeps every depth against each decimation code. It verifies that the line goes idle right after the clamped number of forwarded words. Forwarded bits can only be related to `sdi` at the right sampling edge if the bench plays a downstream device. So the bench drives `sdi` bit by bit, just after each launch, from known words.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOCAL   = 2'd1,
        ST_FORWARD = 2'd2
    } srp_state_e;

    localparam int unsigned STAT_W = 5;
    localparam int unsigned PAD_W  = 3;

endpackage

// File: rtl/srp_clkdiv.sv
module srp_clkdiv (
    input  logic clk,
    input  logic rst_n,
    output logic sco,
    output logic launch,
    output logic capture
);

    logic ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
        end
    end

    assign sco     = ph_q;
    assign launch  = ~ph_q;
    assign capture = ph_q;

    // R1: serial clock alternates every master edge after the first post-reset edge
    assert_sco_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sco != $past(sco)));

endmodule

// File: rtl/srp_frame_builder.sv
module srp_frame_builder #(
    parameter int unsigned DATA_W  = 24,
    parameter int unsigned REG_W   = 16,
    parameter int unsigned FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_stb,
    input  logic [DATA_W-1:0]  word_data,
    input  logic               stat_settled,
    input  logic               stat_ovr,
    input  logic               stat_lowpwr,
    input  logic [1:0]         stat_dec,
    input  logic               rd_stb,
    input  logic [REG_W-1:0]   rd_word,
    input  logic               take,
    output logic               pend_valid,
    output logic [FRAME_W-1:0] frame_word,
    output logic [1:0]         frame_dec
);
    import srp_pkg::*;

    localparam int unsigned RB_PAD = FRAME_W - REG_W;

    logic               pend_q;
    logic [FRAME_W-1:0] conv_q;
    logic [1:0]         dec_q;
    logic               rb_q;
    logic [REG_W-1:0]   rbw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            conv_q <= '0;
            dec_q  <= '0;
        end else if (word_stb) begin
            pend_q <= 1'b1;
            conv_q <= {word_data, stat_settled, stat_ovr, stat_lowpwr,
                       stat_dec, {PAD_W{1'b0}}};
            dec_q  <= stat_dec;
        end else if (take) begin
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q  <= 1'b0;
            rbw_q <= '0;
        end else if (rd_stb) begin
            rb_q  <= 1'b1;
            rbw_q <= rd_word;
        end else if (take) begin
            rb_q  <= 1'b0;
        end
    end

    assign pend_valid = pend_q;
    assign frame_word = rb_q ? {rbw_q, {RB_PAD{1'b0}}} : conv_q;
    assign frame_dec  = dec_q;

    // R9: a pending word is kept until a frame actually takes it
    assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !take) |=> pend_q);

    // R5: a readback request is used by exactly one frame
    assert_rb_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rb_q && !rd_stb) |=> !rb_q);

endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
    parameter int unsigned FRAME_W = 32,
    parameter int unsigned DEPTH_W = 3,
    parameter int unsigned LIM_LO  = 3,
    parameter int unsigned LIM_HI  = 7,
    parameter int unsigned CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               capture,
    input  logic               sco,
    input  logic               pend_valid,
    input  logic [FRAME_W-1:0] frame_word,
    input  logic [1:0]         frame_dec,
    input  logic [DEPTH_W-1:0] chain_depth,
    input  logic               sdi,
    output logic               take,
    output logic               fso_n,
    output logic               sdo
);
    import srp_pkg::*;

    srp_state_e         state_q, state_d;
    logic [FRAME_W-1:0] shreg_q;
    logic               fso_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [DEPTH_W-1:0] fwd_q;
    logic               sdi_cap_q;
    logic               dec_lo_q;

    logic [DEPTH_W-1:0] lim;
    logic [DEPTH_W-1:0] depth_eff;
    logic [CNT_W-1:0]   fwd_last_cnt;
    logic               local_last;
    logic               fwd_last;
    logic [FRAME_W-1:0] shifted;

    assign lim          = (frame_dec == 2'b00) ? DEPTH_W'(LIM_LO) : DEPTH_W'(LIM_HI);
    assign depth_eff    = (chain_depth > lim) ? lim : chain_depth;
    assign fwd_last_cnt = CNT_W'(fwd_q) * CNT_W'(FRAME_W) - CNT_W'(1);
    assign local_last   = (cnt_q == CNT_W'(FRAME_W - 1));
    assign fwd_last     = (cnt_q == fwd_last_cnt);
    assign shifted      = {shreg_q[FRAME_W-2:0], sdi_cap_q};
    assign take         = launch && pend_valid && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (launch && pend_valid) state_d = ST_LOCAL;
            ST_LOCAL:   if (launch && local_last)
                            state_d = (fwd_q != '0) ? ST_FORWARD : ST_IDLE;
            ST_FORWARD: if (launch && fwd_last) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            fso_q     <= 1'b1;
            cnt_q     <= '0;
            fwd_q     <= '0;
            sdi_cap_q <= 1'b0;
            dec_lo_q  <= 1'b0;
        end else begin
            if (capture) sdi_cap_q <= sdi;
            if (launch) begin
                unique case (state_q)
                    ST_IDLE: begin
                        cnt_q <= '0;
                        if (pend_valid) begin
                            shreg_q  <= frame_word;
                            fso_q    <= 1'b0;
                            fwd_q    <= depth_eff;
                            dec_lo_q <= (frame_dec == 2'b00);
                        end else begin
                            shreg_q  <= '0;
                            fso_q    <= 1'b1;
                        end
                    end
                    ST_LOCAL: begin
                        if (local_last) begin
                            cnt_q   <= '0;
                            fso_q   <= 1'b1;
                            shreg_q <= (fwd_q == '0) ? '0 : shifted;
                        end else begin
                            cnt_q   <= cnt_q + CNT_W'(1);
                            shreg_q <= shifted;
                        end
                    end
                    ST_FORWARD: begin
                        if (fwd_last) begin
                            cnt_q   <= '0;
                            shreg_q <= '0;
                        end else begin
                            cnt_q   <= cnt_q + CNT_W'(1);
                            shreg_q <= shifted;
                        end
                    end
                    default: begin
                        cnt_q   <= '0;
                        shreg_q <= '0;
                        fso_q   <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign fso_n = fso_q;
    assign sdo   = shreg_q[FRAME_W-1];

    // checker support: count launches shown with the marker low
    logic [6:0] chk_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chk_run <= '0;
        else if (launch) chk_run <= fso_q ? 7'd0 : chk_run + 7'd1;
    end

    // R2: marker low for exactly one frame width
    assert_fso_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fso_q) |-> (chk_run == 7'(FRAME_W)));

    // R3: outputs move only with a rising serial clock
    assert_launch_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$stable(sdo) || !$stable(fso_q))) |-> sco);

    // R7: forwarding never runs past the limit of the latched rate
    assert_fwd_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FORWARD) |->
        (int'(cnt_q) < (dec_lo_q ? int'(LIM_LO * FRAME_W) : int'(LIM_HI * FRAME_W))));

    // R8: idle line is quiet
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q) == ST_IDLE && state_q == ST_IDLE) |-> (fso_q && !sdo));

endmodule

// File: rtl/serial_result_port.sv
module serial_result_port #(
    parameter int unsigned DATA_W  = 24,
    parameter int unsigned REG_W   = 16,
    parameter int unsigned DEPTH_W = 3,
    parameter int unsigned RATE_LO = 128,
    parameter int unsigned RATE_HI = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_stb,
    input  logic [DATA_W-1:0] word_data,
    input  logic              stat_settled,
    input  logic              stat_ovr,
    input  logic              stat_lowpwr,
    input  logic [1:0]        stat_dec,
    input  logic              rd_stb,
    input  logic [REG_W-1:0]  rd_word,
    input  logic [DEPTH_W-1:0] chain_depth,
    input  logic              sdi,
    output logic              sco,
    output logic              fso_n,
    output logic              sdo
);
    import srp_pkg::*;

    localparam int unsigned FRAME_W = DATA_W + STAT_W + PAD_W;
    localparam int unsigned LIM_LO  = RATE_LO / FRAME_W - 1;
    localparam int unsigned LIM_HI  = RATE_HI / FRAME_W - 1;
    localparam int unsigned CNT_W   = $clog2(LIM_HI * FRAME_W + 1);

    logic               launch;
    logic               capture;
    logic               take;
    logic               pend_valid;
    logic [FRAME_W-1:0] frame_word;
    logic [1:0]         frame_dec;

    srp_clkdiv u_clkdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .sco     (sco),
        .launch  (launch),
        .capture (capture)
    );

    srp_frame_builder #(
        .DATA_W  (DATA_W),
        .REG_W   (REG_W),
        .FRAME_W (FRAME_W)
    ) u_builder (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_stb     (word_stb),
        .word_data    (word_data),
        .stat_settled (stat_settled),
        .stat_ovr     (stat_ovr),
        .stat_lowpwr  (stat_lowpwr),
        .stat_dec     (stat_dec),
        .rd_stb       (rd_stb),
        .rd_word      (rd_word),
        .take         (take),
        .pend_valid   (pend_valid),
        .frame_word   (frame_word),
        .frame_dec    (frame_dec)
    );

    srp_shifter #(
        .FRAME_W (FRAME_W),
        .DEPTH_W (DEPTH_W),
        .LIM_LO  (LIM_LO),
        .LIM_HI  (LIM_HI),
        .CNT_W   (CNT_W)
    ) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .capture     (capture),
        .sco         (sco),
        .pend_valid  (pend_valid),
        .frame_word  (frame_word),
        .frame_dec   (frame_dec),
        .chain_depth (chain_depth),
        .sdi         (sdi),
        .take        (take),
        .fso_n       (fso_n),
        .sdo         (sdo)
    );

endmodule

// File: tb/serial_result_port_bench.sv
`timescale 1ns/1ps
module serial_result_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_stb = 1'b0;
    logic [23:0] word_data = '0;
    logic        stat_settled = 1'b0, stat_ovr = 1'b0, stat_lowpwr = 1'b0;
    logic [1:0]  stat_dec = '0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_word = '0;
    logic [2:0]  chain_depth = '0;
    logic        sdi = 1'b0;
    logic        sco, fso_n, sdo;

    always #2.5 clk = ~clk;

    serial_result_port u_serial_result_port (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word_data(word_data),
        .stat_settled(stat_settled), .stat_ovr(stat_ovr), .stat_lowpwr(stat_lowpwr),
        .stat_dec(stat_dec), .rd_stb(rd_stb), .rd_word(rd_word),
        .chain_depth(chain_depth), .sdi(sdi), .sco(sco), .fso_n(fso_n), .sdo(sdo)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] ds_word [0:7];
    logic        rx_sdo [0:255];
    logic        rx_fso [0:255];
    logic        tail_sdo, tail_fso;
    int          lead;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic ds_bit(input int i);
        return ds_word[(i / 32) % 8][31 - (i % 32)];
    endfunction

    function automatic logic [31:0] conv_exp(input logic [23:0] d, input int st);
        return 32'(d) * 32'd256 + 32'(st) * 32'd8;
    endfunction

    task automatic next_launch();
        do @(negedge clk); while (sco !== 1'b1);
    endtask

    task automatic recv(input int nbits);
        lead = 0;
        do begin next_launch(); lead++; end while (fso_n !== 1'b0 && lead < 600);
        rx_sdo[0] = sdo; rx_fso[0] = fso_n; sdi = ds_bit(0);
        for (int i = 1; i < nbits; i++) begin
            next_launch();
            rx_sdo[i] = sdo; rx_fso[i] = fso_n; sdi = ds_bit(i);
        end
        next_launch();
        tail_sdo = sdo; tail_fso = fso_n; sdi = 1'b0;
    endtask

    function automatic logic [31:0] rx_word(input int base);
        logic [31:0] w = '0;
        for (int i = 0; i < 32; i++) w = {w[30:0], rx_sdo[base + i]};
        return w;
    endfunction

    function automatic int fso_bad(input int nbits);
        int bad = 0;
        for (int i = 0; i < nbits; i++)
            if (rx_fso[i] !== ((i < 32) ? 1'b0 : 1'b1)) bad++;
        return bad;
    endfunction

    task automatic pulse_word(input logic [23:0] d, input int st);
        @(negedge clk);
        word_data = d; stat_settled = st[4]; stat_ovr = st[3];
        stat_lowpwr = st[2]; stat_dec = st[1:0]; word_stb = 1'b1;
        @(negedge clk);
        word_stb = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [23:0] d;
        logic [31:0] w;
        for (int k = 0; k < 8; k++) ds_word[k] = '0;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(sco === 1'b0 && fso_n === 1'b1 && sdo === 1'b0, "R10 reset outputs",
            {29'd0, sco, fso_n, sdo}, 32'h2);
        rst_n = 1'b1;

        // R1: divide-by-two serial clock
        next_launch();
        n = 0;
        do begin @(negedge clk); n++; end while (sco !== 1'b1);
        chk(n == 2, "R1 sco period", 32'(n), 32'd2);

        // R4 R2 R3 R8: every status combination, zero depth
        for (int st = 0; st < 32; st++) begin
            d = 24'(st * 32'h3A5C7 + 32'h123457);
            chain_depth = 3'd0;
            pulse_word(d, st);
            recv(32);
            w = rx_word(0);
            chk(w === conv_exp(d, st), "R4 frame layout", w, conv_exp(d, st));
            chk(fso_bad(32) == 0, "R2 marker width", 32'(fso_bad(32)), 32'd0);
            chk(tail_fso === 1'b1 && tail_sdo === 1'b0, "R8 idle after frame",
                {30'd0, tail_fso, tail_sdo}, 32'h2);
        end

        // R5: register readback for one frame, then results again
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            rd_word = 16'(32'hBEEF + r * 32'h1357); rd_stb = 1'b1;
            @(negedge clk);
            rd_stb = 1'b0;
            pulse_word(24'hA5A5A5, 5'h11);
            recv(32);
            w = rx_word(0);
            chk(w === {rd_word, 16'h0}, "R5 readback frame", w, {rd_word, 16'h0});
            pulse_word(24'(32'h5A0F3C + r), 5'h0A);
            recv(32);
            w = rx_word(0);
            chk(w === conv_exp(24'(32'h5A0F3C + r), 5'h0A), "R5 result resumes", w,
                conv_exp(24'(32'h5A0F3C + r), 5'h0A));
        end

        // R6 R7: every depth under every rate code
        for (int dc = 0; dc < 3; dc++) begin
            for (int dep = 0; dep < 8; dep++) begin
                int lim, nf, st;
                lim = (dc == 0) ? 3 : 7;
                nf = (dep < lim) ? dep : lim;
                st = 16 + dc;
                for (int k = 0; k < 8; k++)
                    ds_word[k] = 32'h9E3779B9 * 32'(k + 1 + dep * 8 + dc * 64) ^ 32'h0F1E2D3C;
                chain_depth = 3'(dep);
                d = 24'(32'h800001 + dep * 32'h1111 + dc);
                pulse_word(d, st);
                recv(32 + 32 * nf);
                w = rx_word(0);
                chk(w === conv_exp(d, st), "R6 local word in chain", w, conv_exp(d, st));
                for (int k = 0; k < nf; k++) begin
                    w = rx_word(32 + 32 * k);
                    chk(w === ds_word[k], "R6 forwarded word", w, ds_word[k]);
                end
                chk(fso_bad(32 + 32 * nf) == 0, "R6 marker high while forwarding",
                    32'(fso_bad(32 + 32 * nf)), 32'd0);
                chk(tail_fso === 1'b1 && tail_sdo === 1'b0, "R7 chain stops at limit",
                    {30'd0, tail_fso, tail_sdo}, 32'h2);
            end
        end

        // R8: downstream input tied low
        for (int k = 0; k < 8; k++) ds_word[k] = '0;
        chain_depth = 3'd2;
        pulse_word(24'hFFFFFF, 5'h1D);
        recv(96);
        w = rx_word(32) | rx_word(64);
        chk(w === 32'd0, "R8 forwarded zeros", w, 32'd0);

        // R9: word strobed in mid-frame waits for the next frame
        chain_depth = 3'd0;
        pulse_word(24'h13579B, 5'h03);
        fork
            recv(32);
            begin
                repeat (20) @(negedge clk);
                word_data = 24'h2468AC; stat_settled = 1'b0; stat_ovr = 1'b1;
                stat_lowpwr = 1'b1; stat_dec = 2'b00; word_stb = 1'b1;
                @(negedge clk);
                word_stb = 1'b0;
            end
        join
        w = rx_word(0);
        chk(w === conv_exp(24'h13579B, 5'h03), "R9 running frame intact", w,
            conv_exp(24'h13579B, 5'h03));
        recv(32);
        w = rx_word(0);
        chk(w === conv_exp(24'h2468AC, 5'h0C), "R9 held word sent", w,
            conv_exp(24'h2468AC, 5'h0C));
        chk(lead == 1, "R9 one idle cycle gap", 32'(lead), 32'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule